// File: doc/BRIEF.md
# Double-Buffered Serial Receiver with Overrun Flag

This block receives asynchronous serial frames on a single input line and hands each finished word to a one-word holding register. The shift register is free again as soon as a word has moved into the holding register. The host can therefore read one word while the next frame is still arriving, and a continuous stream of back-to-back frames is accepted without idle time between them.

The line is resynchronised through two flip-flops. It is then sampled on a 16x oversampling tick that the surrounding logic provides. A frame is a start bit, then 8 or 9 payload bits sent least significant bit first, then a stop bit. When the sender uses parity, the parity bit is the last payload bit.

The host side works through three single-cycle strobes: a status read, a data read and a direct clear of the data-available flag. It sees the held word and two flags: data available and overrun. When it is enabled, a single interrupt output requests service for either flag.

Top module: `uart_rx_dbuf`

## Requirements
- R1: After reset, `rxne`, `ore` and `irq` are 0 and `rx_word` is 0.
- R2: A start bit is a falling edge on the line that is still low 8 ticks later. After it, each payload bit is sampled every 16 ticks. With `len9`=0, the 8 bits received appear in `rx_word[7:0]` (first bit in bit 0), `rx_word[8]` reads 0, and `rxne` goes to 1.
- R3: With `len9`=1, nine payload bits are received and appear in `rx_word[8:0]`, with the first bit in bit 0.
- R4: The last payload bit of a frame, which is the parity bit when the sender uses parity, lands in the top bit for the selected length: bit 7 when `len9`=0 and bit 8 when `len9`=1.
- R5: A one-cycle pulse on `data_rd` clears `rxne`.
- R6: A one-cycle pulse on `rxne_clr` clears `rxne` and leaves `rx_word` unchanged.
- R7: If a new word is finished while `rxne` is 1, `ore` goes to 1. The unread word in `rx_word` is kept and the new word is dropped.
- R8: `ore` is cleared only by a `stat_rd` pulse followed by a later `data_rd` pulse. A `data_rd` pulse with no `stat_rd` before it leaves `ore` at 1.
- R9: `irq` is 1 exactly when `irq_en` is 1 and at least one of `rxne` and `ore` is 1.
- R10: Frames are received only while both `blk_en` and `rx_en` are 1. If either is 0, a frame on the line leaves `rxne` and `rx_word` unchanged.
- R11: A low pulse on the line that has ended before the 8th tick after the falling edge is rejected and produces no word. A correct frame that follows it is received normally.
- R12: Two frames sent back to back with no idle time are both received. The first word can be read while the second frame is still arriving.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | 16x oversampling enable, one clock wide per tick |
| rx_pin | input | 1 | Serial line, idles high |
| blk_en | input | 1 | Global block enable |
| rx_en | input | 1 | Receiver enable |
| len9 | input | 1 | 1 for 9 payload bits, 0 for 8 payload bits |
| irq_en | input | 1 | Interrupt enable for both flags |
| stat_rd | input | 1 | Status read strobe |
| data_rd | input | 1 | Data read strobe |
| rxne_clr | input | 1 | Direct clear of the data-available flag |
| rx_word | output | 9 | Held received word |
| rxne | output | 1 | Data-available flag |
| ore | output | 1 | Overrun flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume three things about the inputs. The host strobes are single-cycle pulses. The line holds each bit for the full 16 ticks. `os_tick` is never high on two clocks in a row.

The bench raises the tick on every second clock, so one bit lasts 32 clocks. It drives the line for whole bit periods only. It issues strobes when no word is being delivered. In the back-to-back case the read is timed to fall inside the second frame, well clear of both delivery cycles.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  always_comb ff_d = {ff_q[STAGES-2:0], d_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= '1;
    else        ff_q <= ff_d;
  end

  assign d_out = ff_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              active,
  input  logic              line,
  input  logic              len_full,
  output logic              word_vld,
  output logic [DATA_W-1:0] word
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] MID_L = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] END_L = CW'(OVS - 1);

  rx_state_e         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              prev_q, prev_d;
  logic              vld_q, vld_d;
  logic [IW-1:0]     last_idx;

  assign last_idx = len_full ? IW'(DATA_W - 1) : IW'(DATA_W - 2);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    prev_d  = prev_q;
    vld_d   = 1'b0;
    if (!active) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      prev_d  = 1'b1;
    end else if (tick) begin
      prev_d = line;
      cnt_d  = cnt_q + 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          cnt_d = '0;
          if (prev_q && !line) state_d = ST_START;
        end
        ST_START: begin
          if (cnt_q == MID_L) begin
            cnt_d   = '0;
            idx_d   = '0;
            state_d = line ? ST_IDLE : ST_BITS;
          end
        end
        ST_BITS: begin
          if (cnt_q == END_L) begin
            sh_d  = {line, sh_q[DATA_W-1:1]};
            idx_d = idx_q + 1'b1;
            if (idx_q == last_idx) state_d = ST_STOP;
          end
        end
        ST_STOP: begin
          if (cnt_q == END_L) begin
            vld_d   = 1'b1;
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      prev_q  <= 1'b1;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      prev_q  <= prev_d;
      vld_q   <= vld_d;
    end
  end

  assign word_vld = vld_q;
  assign word     = len_full ? sh_q : {1'b0, sh_q[DATA_W-1:1]};
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  logic [DATA_W-1:0] word,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              rxne_clr,
  output logic [DATA_W-1:0] data,
  output logic              rxne,
  output logic              ore
);
  logic [DATA_W-1:0] data_q, data_d;
  logic              rxne_q, rxne_d;
  logic              ore_q, ore_d;
  logic              armed_q, armed_d;
  logic              rxne_left;

  always_comb begin
    data_d    = data_q;
    ore_d     = ore_q;
    armed_d   = armed_q;
    rxne_left = rxne_q & ~data_rd & ~rxne_clr;
    rxne_d    = rxne_left;
    if (data_rd) begin
      if (armed_q) ore_d = 1'b0;
      armed_d = 1'b0;
    end
    if (stat_rd) armed_d = 1'b1;
    if (word_vld) begin
      if (rxne_left) begin
        ore_d = 1'b1;
      end else begin
        data_d = word;
        rxne_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      rxne_q  <= 1'b0;
      ore_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      rxne_q  <= rxne_d;
      ore_q   <= ore_d;
      armed_q <= armed_d;
    end
  end

  assign data = data_q;
  assign rxne = rxne_q;
  assign ore  = ore_q;
endmodule

// File: rtl/uart_rx_dbuf.sv
module uart_rx_dbuf #(
  parameter int OVS    = 16,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_pin,
  input  logic              blk_en,
  input  logic              rx_en,
  input  logic              len9,
  input  logic              irq_en,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              rxne_clr,
  output logic [DATA_W-1:0] rx_word,
  output logic              rxne,
  output logic              ore,
  output logic              irq
);
  logic              line_s;
  logic              active;
  logic              word_vld;
  logic [DATA_W-1:0] word;

  assign active = blk_en & rx_en;

  uart_rx_sync #(.STAGES(2)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (rx_pin),
    .d_out (line_s)
  );

  uart_rx_frame #(.OVS(OVS), .DATA_W(DATA_W)) i_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (os_tick),
    .active   (active),
    .line     (line_s),
    .len_full (len9),
    .word_vld (word_vld),
    .word     (word)
  );

  uart_rx_hold #(.DATA_W(DATA_W)) i_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_vld (word_vld),
    .word     (word),
    .stat_rd  (stat_rd),
    .data_rd  (data_rd),
    .rxne_clr (rxne_clr),
    .data     (rx_word),
    .rxne     (rxne),
    .ore      (ore)
  );

  assign irq = irq_en & (rxne | ore);
endmodule

// File: rtl/uart_rx_dbuf_chk.sv
module uart_rx_dbuf_chk #(
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              blk_en,
  input logic              rx_en,
  input logic              data_rd,
  input logic              rxne_clr,
  input logic [DATA_W-1:0] rx_word,
  input logic              rxne,
  input logic              ore
);
  // R7: overrun can only appear while an unread word is held
  assert_ore_needs_rxne_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ore) |-> $past(rxne));

  // R7: a held, unread word is never overwritten
  assert_word_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rxne) && !$past(data_rd) && !$past(rxne_clr)) |-> $stable(rx_word));

  // R5 / R6: data-available drops only on a read or a direct clear
  assert_rxne_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxne) |-> $past(data_rd || rxne_clr));

  // R8: overrun drops only on a data read
  assert_ore_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ore) |-> $past(data_rd));

  // R10: a new word arrives only if the receiver was enabled
  assert_enable_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxne) |-> $past(blk_en && rx_en, 2));
endmodule

bind uart_rx_dbuf uart_rx_dbuf_chk #(.DATA_W(DATA_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .blk_en   (blk_en),
  .rx_en    (rx_en),
  .data_rd  (data_rd),
  .rxne_clr (rxne_clr),
  .rx_word  (rx_word),
  .rxne     (rxne),
  .ore      (ore)
);

// File: tb/test_uart_rx_dbuf.sv
`timescale 1ns/1ps
module test_uart_rx_dbuf;
  localparam int BITC = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       rx_pin = 1'b1;
  logic       blk_en = 1'b1, rx_en = 1'b1, len9 = 1'b0, irq_en = 1'b0;
  logic       stat_rd = 1'b0, data_rd = 1'b0, rxne_clr = 1'b0;
  logic [8:0] rx_word;
  logic       rxne, ore, irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [8:0] m_word = '0;
  bit m_rxne = 0, m_ore = 0, m_armed = 0;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) os_tick <= 1'b0;
    else        os_tick <= ~os_tick;
  end

  uart_rx_dbuf i_uart_rx_dbuf (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_pin(rx_pin),
    .blk_en(blk_en), .rx_en(rx_en), .len9(len9), .irq_en(irq_en),
    .stat_rd(stat_rd), .data_rd(data_rd), .rxne_clr(rxne_clr),
    .rx_word(rx_word), .rxne(rxne), .ore(ore), .irq(irq)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model compared every clock while no frame is in flight
  always @(posedge clk) begin
    if (cmp_on && rst_n) begin
      #1;
      chk("R2 word", rx_word, m_word);
      chk("R5 rxne", {8'd0, rxne}, {8'd0, m_rxne});
      chk("R7 ore", {8'd0, ore}, {8'd0, m_ore});
      chk("R9 irq", {8'd0, irq}, {8'd0, irq_en & (m_rxne | m_ore)});
    end
  end

  task automatic line_bits(input int n, input logic [8:0] v);
    rx_pin = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rx_pin = v[i];
      repeat (BITC) @(negedge clk);
    end
    rx_pin = 1'b1;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic model_word(input int n, input logic [8:0] v);
    logic [8:0] w;
    w = (n == 9) ? v : {1'b0, v[7:0]};
    if (blk_en && rx_en) begin
      if (m_rxne) m_ore = 1;
      else begin m_word = w; m_rxne = 1; end
    end
  endtask

  task automatic send(input int n, input logic [8:0] v);
    @(negedge clk);
    cmp_on = 0;
    line_bits(n, v);
    repeat (4) @(negedge clk);
    model_word(n, v);
    cmp_on = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_data;
    @(negedge clk); data_rd = 1'b1;
    @(posedge clk);
    m_rxne = 0;
    if (m_armed) m_ore = 0;
    m_armed = 0;
    @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic pulse_stat;
    @(negedge clk); stat_rd = 1'b1;
    @(posedge clk); m_armed = 1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic pulse_clr;
    @(negedge clk); rxne_clr = 1'b1;
    @(posedge clk); m_rxne = 0;
    @(negedge clk); rxne_clr = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rxne", {8'd0, rxne}, 9'd0);
    chk("R1 ore", {8'd0, ore}, 9'd0);
    chk("R1 irq", {8'd0, irq}, 9'd0);
    chk("R1 word", rx_word, 9'd0);
    cmp_on = 1;
    repeat (10) @(negedge clk);

    // R2 eight-bit frame, top bit reads 0
    send(8, 9'h0A5);
    chk("R2 word", rx_word, 9'h0A5);
    chk("R2 rxne", {8'd0, rxne}, 9'd1);
    pulse_data;
    chk("R5 rxne cleared", {8'd0, rxne}, 9'd0);

    // R3 nine-bit frame
    len9 = 1'b1;
    send(9, 9'h1C3);
    chk("R3 word", rx_word, 9'h1C3);
    pulse_data;

    // R4 parity in the top bit: 7 data bits 0x13 even parity -> 1
    len9 = 1'b0;
    send(8, {1'b0, ^7'h13, 7'h13});
    chk("R4 even parity bit7", rx_word, 9'h093);
    pulse_data;
    // R4 nine-bit, 8 data 0x0F odd parity -> 1
    len9 = 1'b1;
    send(9, {~^8'h0F, 8'h0F});
    chk("R4 odd parity bit8", rx_word, 9'h10F);
    // R6 direct clear keeps the word
    pulse_clr;
    chk("R6 rxne", {8'd0, rxne}, 9'd0);
    chk("R6 word kept", rx_word, 9'h10F);

    // R9 interrupt
    len9 = 1'b0;
    irq_en = 1'b1;
    send(8, 9'h03C);
    chk("R9 irq on rxne", {8'd0, irq}, 9'd1);
    pulse_data;
    chk("R9 irq off", {8'd0, irq}, 9'd0);

    // R7 overrun keeps the old word
    send(8, 9'h011);
    send(8, 9'h022);
    chk("R7 ore", {8'd0, ore}, 9'd1);
    chk("R7 old word kept", rx_word, 9'h011);
    chk("R9 irq on ore", {8'd0, irq}, 9'd1);
    // R8 data read alone keeps ore
    pulse_data;
    chk("R8 ore after lone read", {8'd0, ore}, 9'd1);
    pulse_stat;
    pulse_data;
    chk("R8 ore cleared", {8'd0, ore}, 9'd0);
    irq_en = 1'b0;

    // R10 enable gating
    rx_en = 1'b0;
    send(8, 9'h055);
    chk("R10 rx_en off", {8'd0, rxne}, 9'd0);
    rx_en = 1'b1; blk_en = 1'b0;
    send(8, 9'h066);
    chk("R10 blk_en off", {8'd0, rxne}, 9'd0);
    chk("R10 word unchanged", rx_word, 9'h011);
    blk_en = 1'b1;
    repeat (4) @(negedge clk);

    // R11 glitch rejection
    cmp_on = 0;
    rx_pin = 1'b0;
    repeat (4) @(negedge clk);
    rx_pin = 1'b1;
    repeat (BITC * 12) @(negedge clk);
    cmp_on = 1;
    @(negedge clk);
    chk("R11 glitch no word", {8'd0, rxne}, 9'd0);
    send(8, 9'h07E);
    chk("R11 frame after glitch", rx_word, 9'h07E);
    pulse_data;

    // R12 back-to-back frames
    cmp_on = 0;
    fork
      begin
        line_bits(8, 9'h081);
        line_bits(8, 9'h018);
      end
      begin
        @(posedge rxne);
        repeat (20) @(negedge clk);
        chk("R12 first word", rx_word, 9'h081);
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
      end
    join
    repeat (4) @(negedge clk);
    m_word = 9'h018; m_rxne = 1; m_ore = 0; m_armed = 0;
    cmp_on = 1;
    @(negedge clk);
    chk("R12 second word", rx_word, 9'h018);
    chk("R12 no overrun", {8'd0, ore}, 9'd0);
    pulse_data;
    repeat (4) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule